// File: doc/BRIEF.md
# Four-Channel Configurable Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from a single clock. Each channel holds a period count, a duty count and a control word. It can run continuously or for one period only, with the pulse aligned to the start of the period or centred in it. The active level of the pulse and the level held while the channel is stopped are each chosen by a control bit. Period and duty are counts of the input clock. A value written while the channel is running takes effect at the next period boundary, so no output period is cut short.

Software talks to the block through a small 32-bit register bus: a select, a write flag, a byte address and write data, with read data returned one cycle after the read. Each channel has a 16-byte window. A shared pending register and a mask register follow the windows. When a one-shot run ends, the channel sets its pending bit. A single interrupt line is high while any unmasked pending bit is set. The usual programming sequence is: write the control word with the enable bit clear, then write period and duty, then write the control word again with the enable bit set.

Top module: `pwm_quad`

## Requirements
- R1: After reset every output, the interrupt line and every register read as 0.
- R2: Channel n occupies bytes 16n..16n+15: counter at +0x0 (read-only; writes have no effect), period at +0x4, duty at +0x8, control at +0xC. Pending is at 0x40 and mask at 0x44. Control bits 0,1,3,4,5 read back as written and the other bits read 0. Accesses with address bits [1:0] nonzero, and reads of unmapped addresses, return 0 and change nothing. Read data appears in the cycle after the read.
- R3: With control bit 5 = 0 (left-aligned), a running channel's counter steps 0,1,..,P-1 and then wraps, so one period is P clocks. The output is active while counter < D. A period of 0 behaves as 1.
- R4: With control bit 5 = 1 (centre-aligned), the counter steps 0..P-1 and then P-1..0, so one period is 2P clocks. The output is active while counter < D, which gives 2*min(D,P) active clocks placed symmetrically.
- R5: Control bit 3 = 1 makes the active level high; control bit 3 = 0 makes it low.
- R6: While control bit 0 (enable) is 0, the output equals control bit 4. This holds from the clock after the enable bit is cleared.
- R7: A duty of 0 keeps the output inactive for the whole period. A duty of P or more keeps it active for the whole period.
- R8: Period and duty writes go to holding registers. A running channel picks them up only when the enable bit goes from 0 to 1, or at a period boundary.
- R9: With control bit 1 = 0 (one-shot), the channel runs one period, then clears its own enable bit and sets pending bit n. A control write in that same cycle takes precedence over the clear.
- R10: The interrupt line equals the OR over n of (pending bit n AND mask bit n). Writing 1 to a pending bit clears it, and a new set in the same cycle wins over the clear.
- R11: Setting the enable bit from 0 restarts the counter at 0 on the next clock. Rewriting the control word with the enable bit already 1 does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pwm_out | output | 4 | One modulated output per channel |
| irq | output | 1 | Shared interrupt for finished one-shot runs |

## Verification
A wrong counter or direction state shows up on the channel's output within one period. It appears as a pulse edge one or more clocks off, or as a pulse of the wrong width, and the bench checks every output on every clock. A holding register copied into the working register too early distorts the period in which the write was made. A missed copy distorts the following period. A missing one-shot completion leaves the output at its active or inactive level instead of its idle level, one clock after the final count. Pending and mask errors reach the interrupt line in the same clock. The counter is also read back through the bus, so a wrong count is visible there one cycle after the read.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned WIN_B    = 16;
  localparam int unsigned STAT_OFS = 'h40;
  localparam int unsigned MASK_OFS = 'h44;

  localparam logic [1:0] RG_CNT  = 2'd0;
  localparam logic [1:0] RG_PER  = 2'd1;
  localparam logic [1:0] RG_DUTY = 2'd2;
  localparam logic [1:0] RG_CTRL = 2'd3;

  typedef struct packed {
    logic center;
    logic idle_hi;
    logic act_hi;
    logic cont;
    logic en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.center  = w[5];
    c.idle_hi = w[4];
    c.act_hi  = w[3];
    c.cont    = w[1];
    c.en      = w[0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
    return WORD_W'({c.center, c.idle_hi, c.act_hi, 1'b0, c.cont, c.en});
  endfunction
endpackage

// File: rtl/pwmq_channel.sv
module pwmq_channel
  import pwmq_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_per,
  input  logic             wr_duty,
  input  ctrl_t            ctrl_wval,
  input  logic [CNT_W-1:0] num_wval,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] per_sh_q,
  output logic [CNT_W-1:0] duty_sh_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] act_duty_q,
  output logic             start,
  output logic             bound,
  output logic             done,
  output logic             pwm
);
  logic [CNT_W-1:0] act_per_q;
  logic [CNT_W-1:0] cnt_n;
  logic             dir_q, dir_n;
  logic             at_lim, load;
  ctrl_t            ctrl_n;

  // next-state logic
  always_comb begin
    start  = wr_ctrl & ctrl_wval.en & ~ctrl_q.en;
    lim    = (act_per_q == '0) ? '0 : act_per_q - 1'b1;
    at_lim = (cnt_q >= lim);
    cnt_n  = cnt_q;
    dir_n  = dir_q;
    bound  = 1'b0;
    if (start) begin
      cnt_n = '0;
      dir_n = 1'b0;
    end else if (ctrl_q.en) begin
      if (!ctrl_q.center) begin
        dir_n = 1'b0;
        if (at_lim) begin
          cnt_n = '0;
          bound = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (!dir_q) begin
        if (at_lim) dir_n = 1'b1;
        else        cnt_n = cnt_q + 1'b1;
      end else begin
        if (cnt_q == '0) begin
          bound = 1'b1;
          dir_n = 1'b0;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
    done   = bound & ~ctrl_q.cont;
    load   = start | bound;
    ctrl_n = ctrl_q;
    if (wr_ctrl)   ctrl_n    = ctrl_wval;
    else if (done) ctrl_n.en = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      per_sh_q   <= '0;
      duty_sh_q  <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
      cnt_q      <= '0;
      dir_q      <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      cnt_q  <= cnt_n;
      dir_q  <= dir_n;
      if (wr_per)  per_sh_q  <= num_wval;
      if (wr_duty) duty_sh_q <= num_wval;
      if (load) begin
        act_per_q  <= per_sh_q;
        act_duty_q <= duty_sh_q;
      end
    end
  end

  assign pwm = ctrl_q.en ? ((cnt_q < act_duty_q) ? ctrl_q.act_hi : ~ctrl_q.act_hi)
                         : ctrl_q.idle_hi;
endmodule

// File: rtl/pwmq_irq.sv
module pwmq_irq #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done,
  input  logic              wr_stat,
  input  logic              wr_mask,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] stat_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic              irq
);
  logic [NUM_CH-1:0] stat_n;

  always_comb begin
    stat_n = (stat_q & ~(wr_stat ? wbits : '0)) | done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_n;
      if (wr_mask) mask_q <= wbits;
    end
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwmq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic              irq
);
  localparam int unsigned CH_SPAN  = NUM_CH * WIN_B;
  localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                aligned, hit, wr, rd, in_ch;
  logic [CH_IDX_W-1:0] ch_idx;
  logic [1:0]          rsel;
  logic                wr_stat, wr_mask;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign hit     = bus_sel & aligned;
  assign wr      = hit & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign in_ch   = (bus_addr < ADDR_W'(CH_SPAN));
  assign ch_idx  = bus_addr[4 +: CH_IDX_W];
  assign rsel    = bus_addr[3:2];
  assign wr_stat = wr & (bus_addr == ADDR_W'(STAT_OFS));
  assign wr_mask = wr & (bus_addr == ADDR_W'(MASK_OFS));

  ctrl_t                          ctrl_wval;
  logic [NUM_CH-1:0]              ch_wrctrl, ch_wrper, ch_wrduty;
  logic [NUM_CH-1:0]              ch_start, ch_bound, ch_done, ch_en;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt, ch_lim, ch_adut, ch_psh, ch_dsh;
  logic [NUM_CH-1:0][31:0]        ch_rd;
  ctrl_t                          ch_ctrl [NUM_CH];

  assign ctrl_wval = ctrl_from_word(bus_wdata);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_i;
    assign sel_i        = wr & in_ch & (ch_idx == CH_IDX_W'(i));
    assign ch_wrctrl[i] = sel_i & (rsel == RG_CTRL);
    assign ch_wrper[i]  = sel_i & (rsel == RG_PER);
    assign ch_wrduty[i] = sel_i & (rsel == RG_DUTY);
    assign ch_en[i]     = ch_ctrl[i].en;

    pwmq_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .wr_ctrl    (ch_wrctrl[i]),
      .wr_per     (ch_wrper[i]),
      .wr_duty    (ch_wrduty[i]),
      .ctrl_wval  (ctrl_wval),
      .num_wval   (bus_wdata[CNT_W-1:0]),
      .ctrl_q     (ch_ctrl[i]),
      .per_sh_q   (ch_psh[i]),
      .duty_sh_q  (ch_dsh[i]),
      .cnt_q      (ch_cnt[i]),
      .lim        (ch_lim[i]),
      .act_duty_q (ch_adut[i]),
      .start      (ch_start[i]),
      .bound      (ch_bound[i]),
      .done       (ch_done[i]),
      .pwm        (pwm_out[i])
    );

    always_comb begin
      unique case (rsel)
        RG_CNT:  ch_rd[i] = 32'(ch_cnt[i]);
        RG_PER:  ch_rd[i] = 32'(ch_psh[i]);
        RG_DUTY: ch_rd[i] = 32'(ch_dsh[i]);
        default: ch_rd[i] = ctrl_to_word(ch_ctrl[i]);
      endcase
    end
  end

  logic [NUM_CH-1:0] stat_q, mask_q;

  pwmq_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .done    (ch_done),
    .wr_stat (wr_stat),
    .wr_mask (wr_mask),
    .wbits   (bus_wdata[NUM_CH-1:0]),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  logic [31:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (in_ch)                                  rd_val = ch_rd[ch_idx];
      else if (bus_addr == ADDR_W'(STAT_OFS))     rd_val = 32'(stat_q);
      else if (bus_addr == ADDR_W'(MASK_OFS))     rd_val = 32'(mask_q);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd)     rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        irq,
  input logic [NUM_CH-1:0]           stat_q,
  input logic [NUM_CH-1:0]           mask_q,
  input logic [NUM_CH-1:0]           ch_done,
  input logic [NUM_CH-1:0]           ch_bound,
  input logic [NUM_CH-1:0]           ch_start,
  input logic [NUM_CH-1:0]           ch_en,
  input logic [NUM_CH-1:0]           ch_wrctrl,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_lim,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_adut
);
  // R10
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R10
  quiet_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    // R9
    done_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[i] |=> stat_q[i]);

    // R9
    done_stops_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_done[i] && !ch_wrctrl[i]) |=> !ch_en[i]);

    // R3
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_en[i] |-> (ch_cnt[i] <= ch_lim[i]));

    // R8
    duty_held_midperiod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_bound[i] && !ch_start[i]) |=> $stable(ch_adut[i]));

    // R11
    start_zeroes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[i] |=> (ch_cnt[i] == '0));
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .ch_done   (ch_done),
  .ch_bound  (ch_bound),
  .ch_start  (ch_start),
  .ch_en     (ch_en),
  .ch_wrctrl (ch_wrctrl),
  .ch_cnt    (ch_cnt),
  .ch_lim    (ch_lim),
  .ch_adut   (ch_adut)
);

// File: tb/pwm_quad_bench.sv
module pwm_quad_bench;
  localparam int N = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic        irq;

  pwm_quad u_pwm_quad (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [5:0]  m_ctrl [N];
  logic [31:0] m_psh [N], m_dsh [N], m_pa [N], m_da [N], m_cnt [N];
  logic        m_dir [N];
  logic [3:0]  m_st, m_msk;
  logic [31:0] m_rd;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_pin(input int i);
    if (!m_ctrl[i][0]) return m_ctrl[i][4];
    return (m_cnt[i] < m_da[i]) ? m_ctrl[i][3] : ~m_ctrl[i][3];
  endfunction

  function automatic logic [31:0] m_read(input logic [6:0] a);
    if (a[1:0] != 2'b00) return 32'd0;
    if (a < 7'h40) begin
      case (a[3:2])
        2'd0: return m_cnt[a[5:4]];
        2'd1: return m_psh[a[5:4]];
        2'd2: return m_dsh[a[5:4]];
        default: return {26'd0, m_ctrl[a[5:4]]};
      endcase
    end
    if (a == 7'h40) return {28'd0, m_st};
    if (a == 7'h44) return {28'd0, m_msk};
    return 32'd0;
  endfunction

  task automatic model_step(input bit s, input bit w, input logic [6:0] a, input logic [31:0] d);
    bit hit = s && (a[1:0] == 2'b00);
    logic [3:0] dn = '0;
    if (s && !w) m_rd = m_read(a);
    for (int i = 0; i < N; i++) begin
      bit chw = hit && w && (a < 7'h40) && (int'(a[5:4]) == i);
      bit wc = chw && (a[3:2] == 2'd3);
      bit wp = chw && (a[3:2] == 2'd1);
      bit wd = chw && (a[3:2] == 2'd2);
      bit st = wc && d[0] && !m_ctrl[i][0];
      bit bnd = 0;
      logic [31:0] lim = (m_pa[i] == 0) ? 32'd0 : m_pa[i] - 1;
      if (st) begin
        m_cnt[i] = 0; m_dir[i] = 0;
      end else if (m_ctrl[i][0]) begin
        if (!m_ctrl[i][5]) begin
          m_dir[i] = 0;
          if (m_cnt[i] >= lim) begin m_cnt[i] = 0; bnd = 1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end else if (!m_dir[i]) begin
          if (m_cnt[i] >= lim) m_dir[i] = 1;
          else m_cnt[i] = m_cnt[i] + 1;
        end else begin
          if (m_cnt[i] == 0) begin bnd = 1; m_dir[i] = 0; end
          else m_cnt[i] = m_cnt[i] - 1;
        end
      end
      if (st || bnd) begin m_pa[i] = m_psh[i]; m_da[i] = m_dsh[i]; end
      dn[i] = bnd && !m_ctrl[i][1];
      if (wc) m_ctrl[i] = d[5:0] & 6'h3B;
      else if (dn[i]) m_ctrl[i][0] = 1'b0;
      if (wp) m_psh[i] = d;
      if (wd) m_dsh[i] = d;
    end
    m_st = (m_st & ~((hit && w && a == 7'h40) ? d[3:0] : 4'h0)) | dn;
    if (hit && w && a == 7'h44) m_msk = d[3:0];
  endtask

  task automatic cmp_outs();
    for (int i = 0; i < N; i++)
      check(pwm_out[i] == m_pin(i), m_ctrl[i][5] ? "R4" : "R3",
            $sformatf("ch%0d output", i), 32'(pwm_out[i]), 32'(m_pin(i)));
    check(irq == |(m_st & m_msk), "R10", "irq", 32'(irq), 32'(|(m_st & m_msk)));
  endtask

  task automatic step(input bit s, input bit w, input logic [6:0] a, input logic [31:0] d);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    model_step(s, w, a, d);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    cmp_outs();
  endtask

  task automatic idle(); step(0, 0, 7'h0, 32'h0); endtask
  task automatic wr(input logic [6:0] a, input logic [31:0] d); step(1, 1, a, d); endtask

  task automatic rd_check(input logic [6:0] a, input logic [31:0] exp, input string tag);
    step(1, 0, a, 32'h0);
    check(bus_rdata == exp, tag, $sformatf("read %0h", a), bus_rdata, exp);
  endtask

  task automatic count_hi(input int ch, input int n, output int ones);
    ones = 0;
    for (int k = 0; k < n; k++) begin
      ones += int'(pwm_out[ch]);
      idle();
    end
  endtask

  initial begin
    int ones;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < N; i++) begin
      m_ctrl[i] = 0; m_psh[i] = 0; m_dsh[i] = 0; m_pa[i] = 0;
      m_da[i] = 0; m_cnt[i] = 0; m_dir[i] = 0;
    end
    m_st = 0; m_msk = 0; m_rd = 0;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) idle();

    // R1 reset state
    check(pwm_out == 4'h0, "R1", "outputs", 32'(pwm_out), 0);
    check(irq == 1'b0, "R1", "irq", 32'(irq), 0);
    rd_check(7'h1C, 32'h0, "R1");
    rd_check(7'h40, 32'h0, "R1");

    // R2 map, readback, misaligned, counter read-only
    wr(7'h1C, 32'h3E);
    rd_check(7'h1C, 32'h3A, "R2");
    wr(7'h14, 32'h1234);
    rd_check(7'h14, 32'h1234, "R2");
    wr(7'h15, 32'hFF);
    rd_check(7'h14, 32'h1234, "R2");
    rd_check(7'h16, 32'h0, "R2");
    wr(7'h1C, 32'h0);

    // R3 left-aligned, period 5 duty 2
    wr(7'h0C, 32'h0A); wr(7'h04, 5); wr(7'h08, 2); wr(7'h0C, 32'h0B);
    count_hi(0, 10, ones);
    check(ones == 4, "R3", "ch0 high count", ones, 4);

    // R4 centre-aligned, period 4 duty 1
    wr(7'h1C, 32'h2A); wr(7'h14, 4); wr(7'h18, 1); wr(7'h1C, 32'h2B);
    count_hi(1, 16, ones);
    check(ones == 4, "R4", "ch1 high count", ones, 4);

    // R5 active-low pulse
    wr(7'h2C, 32'h12); wr(7'h24, 4); wr(7'h28, 1); wr(7'h2C, 32'h13);
    count_hi(2, 8, ones);
    check(ones == 6, "R5", "ch2 high count", ones, 6);

    // R6 idle level
    wr(7'h2C, 32'h12);
    check(pwm_out[2] == 1'b1, "R6", "ch2 idle high", 32'(pwm_out[2]), 1);
    check(pwm_out[3] == 1'b0, "R6", "ch3 idle low", 32'(pwm_out[3]), 0);
    wr(7'h3C, 32'h10);
    check(pwm_out[3] == 1'b1, "R6", "ch3 idle high", 32'(pwm_out[3]), 1);

    // R7 duty extremes on ch0 (period 5)
    wr(7'h08, 0);
    repeat (6) idle();
    count_hi(0, 5, ones);
    check(ones == 0, "R7", "duty 0", ones, 0);
    wr(7'h08, 9);
    repeat (6) idle();
    count_hi(0, 5, ones);
    check(ones == 5, "R7", "duty over period", ones, 5);

    // R8 duty change waits for boundary
    wr(7'h0C, 32'h0A); wr(7'h04, 6); wr(7'h08, 0); wr(7'h0C, 32'h0B);
    check(pwm_out[0] == 1'b0, "R8", "start", 32'(pwm_out[0]), 0);
    idle();
    wr(7'h08, 6);
    check(pwm_out[0] == 1'b0, "R8", "after write", 32'(pwm_out[0]), 0);
    for (int k = 0; k < 3; k++) begin
      idle();
      check(pwm_out[0] == 1'b0, "R8", "before boundary", 32'(pwm_out[0]), 0);
    end
    idle();
    check(pwm_out[0] == 1'b1, "R8", "after boundary", 32'(pwm_out[0]), 1);

    // R9 one-shot on ch3
    wr(7'h44, 0);
    wr(7'h3C, 32'h08); wr(7'h34, 3); wr(7'h38, 1); wr(7'h3C, 32'h09);
    check(pwm_out[3] == 1'b1, "R9", "first clock", 32'(pwm_out[3]), 1);
    idle(); idle(); idle();
    check(pwm_out[3] == 1'b0, "R9", "idle after run", 32'(pwm_out[3]), 0);
    rd_check(7'h3C, 32'h08, "R9");
    rd_check(7'h40, 32'h8, "R9");
    check(irq == 1'b0, "R10", "masked", 32'(irq), 0);

    // R10 mask and write-one-to-clear
    wr(7'h44, 32'h8);
    check(irq == 1'b1, "R10", "unmasked", 32'(irq), 1);
    wr(7'h40, 32'h1);
    check(irq == 1'b1, "R10", "other bit cleared", 32'(irq), 1);
    wr(7'h40, 32'h8);
    check(irq == 1'b0, "R10", "cleared", 32'(irq), 0);
    rd_check(7'h40, 32'h0, "R10");

    // R11 restart only on enable rising
    wr(7'h0C, 32'h0A); wr(7'h04, 100); wr(7'h0C, 32'h0B);
    repeat (5) idle();
    rd_check(7'h00, 5, "R11");
    wr(7'h0C, 32'h0B);
    rd_check(7'h00, 7, "R11");
    wr(7'h00, 32'h55);
    rd_check(7'h00, 9, "R2");

    // random traffic against the reference
    for (int k = 0; k < 3000; k++) begin
      int op = int'($urandom_range(0, 9));
      int sel = int'($urandom_range(0, 17));
      logic [6:0] a = (sel < 16) ? 7'((sel / 4) * 16 + (sel % 4) * 4)
                                 : ((sel == 16) ? 7'h40 : 7'h44);
      logic [31:0] d;
      case (sel % 4)
        1: d = $urandom_range(0, 8);
        2: d = $urandom_range(0, 10);
        3: d = $urandom_range(0, 63);
        default: d = $urandom_range(0, 15);
      endcase
      if (sel >= 16) d = $urandom_range(0, 15);
      if (op < 4) idle();
      else if (op < 7) wr(a, d);
      else begin
        if (op == 9) a = 7'h48;
        step(1, 0, a, 32'h0);
        check(bus_rdata == m_rd, "R2", $sformatf("random read %0h", a), bus_rdata, m_rd);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule